// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state with no help from software. After reset it holds the clock enable low and drives a deselect on the command pins for a programmable stable-power interval. It then raises the clock enable and issues one NOP. After that it issues a precharge of all banks, eight auto-refresh commands and a mode register load. When the low-power device input is high, it also issues an extended mode register load. Each command is separated from the next by a wait whose length is a parameter.

When the last wait has expired, the block raises `done` and keeps it high until the next reset. The memory controller uses `done` to release normal traffic and the periodic refresh timer. The block carries no data path and does no refresh after initialization. Whenever it is not issuing a command, it drives a NOP. The parameters must satisfy `T_RP`, `T_RC` and `T_MRD` of at least 2, `PWR_CYC` of at least 1, and `ADDR_W` of at least 11.

Cycle numbering below starts at cycle 0, the first clock period after `rst_n` is released. P stands for `PWR_CYC`. A command is written `{cs_n,ras_n,cas_n,we_n}`: deselect is 1111, NOP is 0111, precharge is 0010, auto-refresh is 0001 and mode load is 0000.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, and in cycles 0 to P-1, the outputs hold these values: `cke`=0, command 1111, `addr`=0, `ba`=0 and `done`=0.
- R2: `cke` rises in cycle P, which carries command 1111, and stays high until the next reset.
- R3: Cycle P+1 carries a NOP (0111). Every later cycle that carries none of the commands in R4 to R7 also shows 0111, with `addr`=0 and `ba`=0.
- R4: Cycle P+2 carries a precharge (0010), with `addr` bit 10 = 1, all other address bits 0, and `ba`=00.
- R5: Exactly eight auto-refresh commands (0001) are issued. They fall in cycles P+2+T_RP+k*T_RC for k=0..7, with `addr`=0 and `ba`=0.
- R6: A mode load (0000) with `ba`=00 is issued T_RC cycles after the eighth refresh. In it, `addr[2:0]` = `burst_len`, `addr[3]` = 0, `addr[6:4]` = `cas_lat`, and all other bits are 0.
- R7: If `mobile_en` is high, an extended mode load (0000) with `ba`=10 follows T_MRD cycles after the mode load. In it, `addr[2:0]` = `pasr`, `addr[4:3]` = `tcsr`, `addr[6:5]` = `drv_str`, and all other bits are 0. If `mobile_en` is low, no command is issued at that cycle.
- R8: `done` rises exactly T_MRD cycles after the last mode-register command. It stays high until reset, and only NOPs with `cke`=1 are driven after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mobile_en | input | 1 | Low-power device; enables the extended mode load |
| cas_lat | input | 3 | CAS latency code for the mode load |
| burst_len | input | 3 | Burst length code for the mode load |
| tcsr | input | 2 | Temperature-compensated self-refresh code |
| drv_str | input | 2 | Output drive strength code |
| pasr | input | 3 | Partial-array self-refresh code |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| done | output | 1 | Initialization complete |

## Verification
The bench builds the block with `PWR_CYC`=200, `T_RP`=3, `T_RC`=7 and `T_MRD`=2. With these values a whole sequence takes a few hundred cycles, so the bench can run it several times. All three inter-command gaps differ, so a gap that uses the wrong parameter, or is off by one, moves a command to a cycle where the reference model expects something else. The runs cover the sequence without and with the extended mode load, using different mode codes. One run is cut off by a reset in the middle of the refresh series.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W  = 13,
  parameter int PWR_CYC = 20000,
  parameter int T_RP    = 3,
  parameter int T_RC    = 8,
  parameter int T_MRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mobile_en,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        burst_len,
  input  logic [1:0]        tcsr,
  input  logic [1:0]        drv_str,
  input  logic [2:0]        pasr,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              done
);
  localparam int REF_TOTAL = 8;
  localparam int GAP_MAX   = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int MAXC      = (PWR_CYC > GAP_MAX) ? PWR_CYC : GAP_MAX;
  localparam int CW        = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_PWR, S_CKE, S_NOP, S_PRE, S_REF, S_MRS, S_EMRS, S_WAIT, S_DONE
  } st_t;

  st_t           st, after;
  logic [CW-1:0] cnt;
  logic [3:0]    refs;
  logic [3:0]    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PWR;
      after <= S_CKE;
      cnt   <= CW'(PWR_CYC - 1);
      refs  <= '0;
    end else begin
      case (st)
        S_PWR, S_WAIT: begin
          if (cnt == '0) st <= after;
          else           cnt <= cnt - 1'b1;
        end
        S_CKE: st <= S_NOP;
        S_NOP: st <= S_PRE;
        S_PRE: begin
          st    <= S_WAIT;
          cnt   <= CW'(T_RP - 2);
          after <= S_REF;
        end
        S_REF: begin
          refs  <= refs + 1'b1;
          st    <= S_WAIT;
          cnt   <= CW'(T_RC - 2);
          after <= (refs == 4'(REF_TOTAL - 1)) ? S_MRS : S_REF;
        end
        S_MRS: begin
          st    <= S_WAIT;
          cnt   <= CW'(T_MRD - 2);
          after <= mobile_en ? S_EMRS : S_DONE;
        end
        S_EMRS: begin
          st    <= S_WAIT;
          cnt   <= CW'(T_MRD - 2);
          after <= S_DONE;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_comb begin
    addr = '0;
    ba   = 2'b00;
    case (st)
      S_PWR, S_CKE:  cmd = 4'b1111;
      S_PRE: begin
        cmd      = 4'b0010;
        addr[10] = 1'b1;
      end
      S_REF:         cmd = 4'b0001;
      S_MRS: begin
        cmd       = 4'b0000;
        addr[2:0] = burst_len;
        addr[6:4] = cas_lat;
      end
      S_EMRS: begin
        cmd       = 4'b0000;
        ba        = 2'b10;
        addr[2:0] = pasr;
        addr[4:3] = tcsr;
        addr[6:5] = drv_str;
      end
      default:       cmd = 4'b0111;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke  = (st != S_PWR);
  assign done = (st == S_DONE);

  assert_no_cmd_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n && ras_n && cas_n && we_n && !done));

  assert_cke_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_pre_then_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |=> (cmd == 4'b0111));

  assert_ref_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> (refs < 4'(REF_TOTAL)));

  assert_ext_only_mobile_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000 && ba == 2'b10) |-> mobile_en);

  assert_mode_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |=> !done);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && cmd == 4'b0111));
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int AW  = 13;
  localparam int P   = 200;
  localparam int RP  = 3;
  localparam int RC  = 7;
  localparam int MRD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mobile_en = 1'b0;
  logic [2:0] cas_lat = 3'd0, burst_len = 3'd0, pasr = 3'd0;
  logic [1:0] tcsr = 2'd0, drv_str = 2'd0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [AW-1:0] addr;
  logic [1:0] ba;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .PWR_CYC(P), .T_RP(RP), .T_RC(RC), .T_MRD(MRD)) uut (
    .clk(clk), .rst_n(rst_n), .mobile_en(mobile_en), .cas_lat(cas_lat),
    .burst_len(burst_len), .tcsr(tcsr), .drv_str(drv_str), .pasr(pasr),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .done(done));

  task automatic compare(input string rq, input logic e_cke, input logic [3:0] e_cmd,
                         input logic [AW-1:0] e_addr, input logic [1:0] e_ba, input logic e_done);
    logic [AW+8:0] act, exp;
    act = {cke, cs_n, ras_n, cas_n, we_n, addr, ba, done};
    exp = {e_cke, e_cmd, e_addr, e_ba, e_done};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", rq, $time, act, exp);
    end
  endtask

  task automatic run(input logic mob, input logic [2:0] cl, input logic [2:0] bl,
                     input logic [1:0] tc, input logic [1:0] ds, input logic [2:0] pa,
                     input int stop_at);
    int pre, r0, mrs, emrs, dn, last;
    @(negedge clk);
    rst_n = 1'b0;
    mobile_en = mob; cas_lat = cl; burst_len = bl; tcsr = tc; drv_str = ds; pasr = pa;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare("R1", 1'b0, 4'b1111, '0, 2'b00, 1'b0);
    end
    rst_n = 1'b1;
    pre  = P + 2;
    r0   = pre + RP;
    mrs  = r0 + 8 * RC;
    emrs = mrs + MRD;
    last = mob ? emrs : mrs;
    dn   = last + MRD;
    for (int t = 0; t < stop_at; t++) begin
      logic e_cke; logic [3:0] e_cmd; logic [AW-1:0] e_addr; logic [1:0] e_ba;
      string rq;
      e_cke = (t >= P);
      e_cmd = (t <= P) ? 4'b1111 : 4'b0111;
      e_addr = '0; e_ba = 2'b00;
      rq = (t < P) ? "R1" : (t == P) ? "R2" : (t >= dn) ? "R8" : "R3";
      if (t == pre) begin
        e_cmd = 4'b0010; e_addr[10] = 1'b1; rq = "R4";
      end
      for (int k = 0; k < 8; k++)
        if (t == r0 + k * RC) begin e_cmd = 4'b0001; rq = "R5"; end
      if (t == mrs) begin
        e_cmd = 4'b0000; e_addr[2:0] = bl; e_addr[6:4] = cl; rq = "R6";
      end
      if (t == emrs) begin
        rq = "R7";
        if (mob) begin
          e_cmd = 4'b0000; e_ba = 2'b10;
          e_addr[2:0] = pa; e_addr[4:3] = tc; e_addr[6:5] = ds;
        end
      end
      compare(rq, e_cke, e_cmd, e_addr, e_ba, t >= dn);
      @(negedge clk);
    end
  endtask

  initial begin
    run(1'b0, 3'd2, 3'd3, 2'd1, 2'd2, 3'd5, P + 2 + RP + 8 * RC + 3 * MRD + 20);
    run(1'b1, 3'd3, 3'd2, 2'd3, 2'd1, 3'd6, P + 2 + RP + 8 * RC + 3 * MRD + 20);
    run(1'b1, 3'd1, 3'd7, 2'd2, 2'd3, 3'd1, P + 2 + RP + 4 * RC);
    run(1'b1, 3'd7, 3'd1, 2'd0, 2'd0, 3'd0, P + 2 + RP + 8 * RC + 3 * MRD + 10);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule